// File: doc/BRIEF.md
# Overlapped Translation and Cache Lookup Unit

This unit serves 32-bit virtual addresses. It reads a 4 KB direct-mapped cache of 32-bit words and translates the address through a small fully associative TLB, both in the same cycle. Pages are 4 KB. The cache line is chosen only from the low address bits, which stay the same through translation. So the line read can start from the raw virtual address while the TLB searches on the virtual page number. The stored tag of each line is a physical page number, and the hit decision compares it with the page number that the TLB returns.

Each request ends in one of four registered results:
- a hit carrying the word;
- a memory read request carrying the translated physical address;
- a translation miss carrying the virtual address, to be handed to a page-table walker;
- a protection fault.

Two separate input ports load the TLB and write a word returned from memory into the cache. The walker and the memory sit outside this unit.

Top module: `xlat_cache_lookup`

## Requirements
- R1: A request presented with `req_valid` in cycle n produces exactly one response with `resp_valid` high in cycle n+2 (after the second rising edge). Requests may be issued every cycle. With no request there is no response.
- R2: For a translated result (hit or memory request), `resp_addr` is the physical page number from the TLB joined with virtual address bits 11..0, which pass through unchanged.
- R3: The status is hit (`resp_status`=0) when the TLB hits, the access is permitted, and the line at index vaddr[11:2] is valid with a tag equal to the translated physical page. `resp_data` then carries the line's word. For every other status `resp_data` is zero.
- R4: When the TLB hits and the access is permitted but the line is invalid or holds another physical page, the status is memory request (1) and `resp_addr` is the physical address.
- R5: When no valid TLB entry matches the virtual page, the status is translation miss (2), whatever the cache holds. `resp_addr` is the full virtual address and `resp_flags` is zero.
- R6: Access kinds are load (0), store (1) and fetch (2). They need rights bit 0 (read), bit 1 (write) and bit 2 (execute) of the matching entry. Kind 3 is never permitted. A TLB hit without the needed right gives protection fault (3), with `resp_addr` set to the virtual address.
- R7: `resp_flags` reports the matching entry's referenced bit (bit 0) and dirty bit (bit 1) as they stood before this access. Any TLB hit sets the referenced bit. A permitted store sets the dirty bit. A fill clears both.
- R8: Fills go to TLB entries 0,1,…,7 in turn and then wrap. The ninth fill replaces the entry written by the first.
- R9: A refill writes the word and the physical page tag into line refill address bits 9..0 (the word address) and marks the line valid. The line is seen by a request presented in any later cycle.
- R10: After reset there is no response, every TLB entry is invalid, and every cache line is invalid, including lines whose stale tag would match.
- R11: The line index comes only from virtual bits 11..2. Two virtual pages mapped to the same physical page therefore hit the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual byte address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| fill_valid | input | 1 | TLB fill strobe |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_ppn | input | 20 | Physical page number of the new entry |
| fill_rights | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| refill_valid | input | 1 | Cache refill strobe |
| refill_waddr | input | 30 | Physical word address of the returned word |
| refill_data | input | 32 | Returned word |
| resp_valid | output | 1 | Response strobe |
| resp_status | output | 2 | 0 hit, 1 memory request, 2 translation miss, 3 protection fault |
| resp_data | output | 32 | Word on a hit, zero otherwise |
| resp_addr | output | 32 | Physical address (status 0/1) or virtual address (status 2/3) |
| resp_flags | output | 2 | Matching entry's dirty (bit 1) and referenced (bit 0) before the access |

## Verification
The lookup is tried with several kinds of address:
- an empty TLB;
- a mapped page whose line is cold, then the same page after refill;
- a second virtual page aliased to the same physical page;
- a page that maps elsewhere but shares the line index;
- an address with a nonzero byte offset.

Together these separate the four outcomes and show that the tag compare uses the translated page, not the virtual one. Each access kind is sent against read-only and full-rights entries. The returned flags then show which accesses set the referenced and dirty bits. Back-to-back requests check the fixed latency. A run of fills past the TLB size shows which entry is evicted and which survive.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  typedef enum logic [1:0] {
    ST_HIT   = 2'd0,
    ST_MEM   = 2'd1,
    ST_WALK  = 2'd2,
    ST_FAULT = 2'd3
  } xlc_status_e;

  typedef enum logic [1:0] {
    AK_LOAD  = 2'd0,
    AK_STORE = 2'd1,
    AK_FETCH = 2'd2,
    AK_RSVD  = 2'd3
  } xlc_kind_e;

  localparam int RIGHTS_W = 3;

endpackage

// File: rtl/xlc_tlb.sv
module xlc_tlb #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         lk_en,
  input  logic [VPN_W-1:0]             lk_vpn,
  input  logic [1:0]                   lk_kind,
  output logic                         lk_hit,
  output logic [PPN_W-1:0]             lk_ppn,
  output logic                         lk_allowed,
  output logic                         lk_refd,
  output logic                         lk_dirty,
  input  logic                         fill_en,
  input  logic [VPN_W-1:0]             fill_vpn,
  input  logic [PPN_W-1:0]             fill_ppn,
  input  logic [xlc_pkg::RIGHTS_W-1:0] fill_rights
);
  import xlc_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]    ent_vpn    [ENTRIES];
  logic [PPN_W-1:0]    ent_ppn    [ENTRIES];
  logic [RIGHTS_W-1:0] ent_rights [ENTRIES];
  logic [ENTRIES-1:0]  ent_valid;
  logic [ENTRIES-1:0]  ent_refd;
  logic [ENTRIES-1:0]  ent_dirty;
  logic [ENTRIES-1:0]  match;
  logic [RIGHTS_W-1:0] hit_rights;
  logic [IDX_W-1:0]    rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn);
  end

  always_comb begin
    lk_ppn     = '0;
    hit_rights = '0;
    lk_refd    = 1'b0;
    lk_dirty   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_ppn     = lk_ppn | ent_ppn[i];
        hit_rights = hit_rights | ent_rights[i];
        lk_refd    = lk_refd | ent_refd[i];
        lk_dirty   = lk_dirty | ent_dirty[i];
      end
    end
    lk_hit = |match;
    unique case (lk_kind)
      AK_LOAD:  lk_allowed = hit_rights[0];
      AK_STORE: lk_allowed = hit_rights[1];
      AK_FETCH: lk_allowed = hit_rights[2];
      default:  lk_allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      ent_refd  <= '0;
      ent_dirty <= '0;
      rr_q      <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_en && rr_q == IDX_W'(i)) begin
          ent_vpn[i]    <= fill_vpn;
          ent_ppn[i]    <= fill_ppn;
          ent_rights[i] <= fill_rights;
          ent_valid[i]  <= 1'b1;
          ent_refd[i]   <= 1'b0;
          ent_dirty[i]  <= 1'b0;
        end else if (lk_en && match[i]) begin
          ent_refd[i] <= 1'b1;
          if (lk_kind == AK_STORE && lk_allowed) ent_dirty[i] <= 1'b1;
        end
      end
      if (fill_en) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/xlc_line_store.sv
module xlc_line_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_live,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = TAG_W + DATA_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [DEPTH-1:0] live_q;

  // tag and word share one array so a single block RAM holds both
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_data};
    if (rd_en) rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      rd_live <= 1'b0;
    end else begin
      if (wr_en) live_q[wr_idx] <= 1'b1;
      if (rd_en) rd_live <= live_q[rd_idx];
    end
  end

  assign {rd_tag, rd_data} = rd_q;

endmodule

// File: rtl/xlat_cache_lookup.sv
module xlat_cache_lookup #(
  parameter int VA_W           = 32,
  parameter int PA_W           = 32,
  parameter int PAGE_W         = 12,
  parameter int WORD_BYTES_LOG = 2,
  parameter int DATA_W         = 32,
  parameter int TLB_ENTRIES    = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                req_valid,
  input  logic [VA_W-1:0]                     req_vaddr,
  input  logic [1:0]                          req_kind,
  input  logic                                fill_valid,
  input  logic [VA_W-PAGE_W-1:0]              fill_vpn,
  input  logic [PA_W-PAGE_W-1:0]              fill_ppn,
  input  logic [2:0]                          fill_rights,
  input  logic                                refill_valid,
  input  logic [PA_W-WORD_BYTES_LOG-1:0]      refill_waddr,
  input  logic [DATA_W-1:0]                   refill_data,
  output logic                                resp_valid,
  output logic [1:0]                          resp_status,
  output logic [DATA_W-1:0]                   resp_data,
  output logic [((VA_W > PA_W) ? VA_W : PA_W)-1:0] resp_addr,
  output logic [1:0]                          resp_flags
);
  import xlc_pkg::*;

  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int IDX_W  = PAGE_W - WORD_BYTES_LOG;
  localparam int ADDR_W = (VA_W > PA_W) ? VA_W : PA_W;

  // stage 1: request registered, line read in flight
  logic            s1_valid;
  logic [VA_W-1:0] s1_vaddr;
  logic [1:0]      s1_kind;

  logic [PPN_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              line_live;

  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;
  logic             tlb_allowed;
  logic             tlb_refd;
  logic             tlb_dirty;

  xlc_status_e     nxt_status;
  xlc_status_e     status_q;
  logic [PA_W-1:0] phys_addr;
  logic            tag_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_vaddr <= '0;
      s1_kind  <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_vaddr <= req_vaddr;
        s1_kind  <= req_kind;
      end
    end
  end

  xlc_line_store #(
    .IDX_W (IDX_W),
    .TAG_W (PPN_W),
    .DATA_W(DATA_W)
  ) u_lines (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (req_valid),
    .rd_idx (req_vaddr[PAGE_W-1:WORD_BYTES_LOG]),
    .rd_tag (line_tag),
    .rd_data(line_data),
    .rd_live(line_live),
    .wr_en  (refill_valid),
    .wr_idx (refill_waddr[IDX_W-1:0]),
    .wr_tag (refill_waddr[PA_W-WORD_BYTES_LOG-1:IDX_W]),
    .wr_data(refill_data)
  );

  xlc_tlb #(
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .ENTRIES(TLB_ENTRIES)
  ) u_tlb (
    .clk        (clk),
    .rst        (rst),
    .lk_en      (s1_valid),
    .lk_vpn     (s1_vaddr[VA_W-1:PAGE_W]),
    .lk_kind    (s1_kind),
    .lk_hit     (tlb_hit),
    .lk_ppn     (tlb_ppn),
    .lk_allowed (tlb_allowed),
    .lk_refd    (tlb_refd),
    .lk_dirty   (tlb_dirty),
    .fill_en    (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .fill_rights(fill_rights)
  );

  always_comb begin
    phys_addr = {tlb_ppn, s1_vaddr[PAGE_W-1:0]};
    tag_match = line_live && (line_tag == tlb_ppn);
    if (!tlb_hit)          nxt_status = ST_WALK;
    else if (!tlb_allowed) nxt_status = ST_FAULT;
    else if (tag_match)    nxt_status = ST_HIT;
    else                   nxt_status = ST_MEM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      status_q   <= ST_HIT;
      resp_data  <= '0;
      resp_addr  <= '0;
      resp_flags <= '0;
    end else begin
      resp_valid <= s1_valid;
      if (s1_valid) begin
        status_q   <= nxt_status;
        resp_data  <= (nxt_status == ST_HIT) ? line_data : '0;
        resp_addr  <= (nxt_status == ST_HIT || nxt_status == ST_MEM)
                      ? ADDR_W'(phys_addr) : ADDR_W'(s1_vaddr);
        resp_flags <= tlb_hit ? {tlb_dirty, tlb_refd} : 2'b00;
      end
    end
  end

  assign resp_status = status_q;

endmodule

// File: rtl/xlc_lookup_checks.sv
module xlc_lookup_checks #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [1:0]        req_kind,
  input logic              resp_valid,
  input logic [1:0]        resp_status,
  input logic [DATA_W-1:0] resp_data,
  input logic [ADDR_W-1:0] resp_addr,
  input logic [1:0]        resp_flags
);
  import xlc_pkg::*;

  logic            p1_valid, p2_valid;
  logic [VA_W-1:0] p1_vaddr, p2_vaddr;
  logic [1:0]      p1_kind, p2_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_valid <= 1'b0;
      p2_valid <= 1'b0;
      p1_vaddr <= '0;
      p2_vaddr <= '0;
      p1_kind  <= '0;
      p2_kind  <= '0;
    end else begin
      p1_valid <= req_valid;
      p2_valid <= p1_valid;
      p1_vaddr <= req_vaddr;
      p2_vaddr <= p1_vaddr;
      p1_kind  <= req_kind;
      p2_kind  <= p1_kind;
    end
  end

  AST_RESP_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    resp_valid == p2_valid); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> resp_addr[PAGE_W-1:0] == p2_vaddr[PAGE_W-1:0]); // R2
  AST_DATA_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status != ST_HIT) |-> resp_data == '0); // R3
  AST_MISS_KEEPS_VADDR: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == ST_WALK) |-> (resp_addr == ADDR_W'(p2_vaddr) && resp_flags == 2'b00)); // R5
  AST_RSVD_KIND_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && p2_kind == AK_RSVD && resp_status != ST_WALK) |-> resp_status == ST_FAULT); // R6
  AST_FAULT_KEEPS_VADDR: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == ST_FAULT) |-> resp_addr == ADDR_W'(p2_vaddr)); // R6

endmodule

bind xlat_cache_lookup xlc_lookup_checks #(
  .VA_W  (VA_W),
  .PAGE_W(PAGE_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_checks (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_vaddr  (req_vaddr),
  .req_kind   (req_kind),
  .resp_valid (resp_valid),
  .resp_status(resp_status),
  .resp_data  (resp_data),
  .resp_addr  (resp_addr),
  .resp_flags (resp_flags)
);

// File: tb/xlat_cache_lookup_test.sv
module xlat_cache_lookup_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [19:0] fill_ppn;
  logic [2:0]  fill_rights;
  logic        refill_valid;
  logic [29:0] refill_waddr;
  logic [31:0] refill_data;
  logic        resp_valid;
  logic [1:0]  resp_status;
  logic [31:0] resp_data;
  logic [31:0] resp_addr;
  logic [1:0]  resp_flags;

  int  total  = 0;
  int  failed = 0;
  bit  done   = 0;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2, RS = 2'd3;
  localparam logic [1:0] S_HIT = 2'd0, S_MEM = 2'd1, S_WALK = 2'd2, S_FLT = 2'd3;

  always #2 clk = ~clk;

  xlat_cache_lookup uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rights(fill_rights),
    .refill_valid(refill_valid), .refill_waddr(refill_waddr), .refill_data(refill_data),
    .resp_valid(resp_valid), .resp_status(resp_status), .resp_data(resp_data),
    .resp_addr(resp_addr), .resp_flags(resp_flags)
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tlb_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] rights);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = rights;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic mem_refill(input logic [31:0] paddr, input logic [31:0] data);
    @(negedge clk);
    refill_valid = 1'b1; refill_waddr = paddr[31:2]; refill_data = data;
    @(negedge clk);
    refill_valid = 1'b0;
  endtask

  // one request, response sampled two edges later; all fields compared
  task automatic expect_lookup(input string rq, input logic [31:0] va, input logic [1:0] kind,
                               input logic [1:0] st, input logic [31:0] data,
                               input logic [31:0] addr, input logic [1:0] flags);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    check({rq, " R1 no early response"}, {63'd0, resp_valid}, 64'd0);
    @(negedge clk);
    check({rq, " R1 response valid"}, {63'd0, resp_valid}, 64'd1);
    check({rq, " status"}, {62'd0, resp_status}, {62'd0, st});
    check({rq, " data"}, {32'd0, resp_data}, {32'd0, data});
    check({rq, " addr"}, {32'd0, resp_addr}, {32'd0, addr});
    check({rq, " flags"}, {62'd0, resp_flags}, {62'd0, flags});
  endtask

  task automatic t_reset_state;
    check("R10 resp_valid after reset", {63'd0, resp_valid}, 64'd0);
    expect_lookup("R10 empty TLB", 32'h0000_0000, LD, S_WALK, 32'h0, 32'h0000_0000, 2'b00);
    tlb_fill(20'h00000, 20'h00000, 3'b111);   // entry 0
    expect_lookup("R10 lines invalid, tag 0 misses", 32'h0000_0010, LD, S_MEM, 32'h0, 32'h0000_0010, 2'b00);
  endtask

  task automatic t_walk;
    expect_lookup("R5 unmapped page", 32'h1234_5678, LD, S_WALK, 32'h0, 32'h1234_5678, 2'b00);
  endtask

  task automatic t_miss_then_hit;
    tlb_fill(20'h12345, 20'h00ABC, 3'b111);   // entry 1
    expect_lookup("R4 R2 cold line", 32'h1234_5678, LD, S_MEM, 32'h0, 32'h00AB_C678, 2'b00);
    mem_refill(32'h00AB_C678, 32'hDEAD_BEEF);
    expect_lookup("R9 R3 after refill", 32'h1234_5678, LD, S_HIT, 32'hDEAD_BEEF, 32'h00AB_C678, 2'b01);
  endtask

  task automatic t_dirty;
    expect_lookup("R7 store hit", 32'h1234_5678, ST, S_HIT, 32'hDEAD_BEEF, 32'h00AB_C678, 2'b01);
    expect_lookup("R7 dirty after store", 32'h1234_5678, LD, S_HIT, 32'hDEAD_BEEF, 32'h00AB_C678, 2'b11);
  endtask

  task automatic t_rights;
    tlb_fill(20'h00020, 20'h00ABC, 3'b001);   // entry 2, read only, aliases page ABC
    expect_lookup("R11 alias hits same line", 32'h0002_0678, LD, S_HIT, 32'hDEAD_BEEF, 32'h00AB_C678, 2'b00);
    expect_lookup("R6 store without write right", 32'h0002_0678, ST, S_FLT, 32'h0, 32'h0002_0678, 2'b01);
    expect_lookup("R6 fetch without execute right", 32'h0002_0678, FE, S_FLT, 32'h0, 32'h0002_0678, 2'b01);
    expect_lookup("R7 faulted store leaves dirty clear", 32'h0002_0678, LD, S_HIT, 32'hDEAD_BEEF, 32'h00AB_C678, 2'b01);
    expect_lookup("R6 reserved kind", 32'h1234_5678, RS, S_FLT, 32'h0, 32'h1234_5678, 2'b11);
    expect_lookup("R6 fetch with execute right", 32'h1234_5678, FE, S_HIT, 32'hDEAD_BEEF, 32'h00AB_C678, 2'b11);
  endtask

  task automatic t_conflict;
    tlb_fill(20'h00030, 20'h00777, 3'b111);   // entry 3, same index, other page
    expect_lookup("R3 R4 tag mismatch", 32'h0003_0678, LD, S_MEM, 32'h0, 32'h0077_7678, 2'b00);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h1234_5678; req_kind = LD;
    @(negedge clk);
    req_vaddr = 32'h9999_9000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 first of pair valid", {63'd0, resp_valid}, 64'd1);
    check("R3 first of pair hit", {62'd0, resp_status}, {62'd0, S_HIT});
    check("R3 first of pair data", {32'd0, resp_data}, {32'd0, 32'hDEAD_BEEF});
    @(negedge clk);
    check("R1 second of pair valid", {63'd0, resp_valid}, 64'd1);
    check("R5 second of pair walk", {62'd0, resp_status}, {62'd0, S_WALK});
    check("R5 second of pair addr", {32'd0, resp_addr}, {32'd0, 32'h9999_9000});
    @(negedge clk);
    check("R1 no response without request", {63'd0, resp_valid}, 64'd0);
  endtask

  task automatic t_byte_offset;
    expect_lookup("R2 byte offset kept", 32'h0003_067B, LD, S_MEM, 32'h0, 32'h0077_767B, 2'b01);
    mem_refill(32'h0077_767B, 32'h0BAD_F00D);
    expect_lookup("R9 refill replaces line", 32'h0003_067B, LD, S_HIT, 32'h0BAD_F00D, 32'h0077_767B, 2'b01);
    expect_lookup("R9 old page now misses", 32'h1234_5678, LD, S_MEM, 32'h0, 32'h00AB_C678, 2'b11);
  endtask

  task automatic t_round_robin;
    for (int i = 0; i < 4; i++) tlb_fill(20'h00040 + 20'(i), 20'h00140 + 20'(i), 3'b111); // entries 4..7
    tlb_fill(20'h00050, 20'h00250, 3'b111);   // wraps to entry 0
    tlb_fill(20'h00051, 20'h00251, 3'b111);   // entry 1
    tlb_fill(20'h00052, 20'h00252, 3'b111);   // entry 2
    expect_lookup("R8 first victim gone", 32'h0000_0010, LD, S_WALK, 32'h0, 32'h0000_0010, 2'b00);
    expect_lookup("R8 second victim gone", 32'h1234_5678, LD, S_WALK, 32'h0, 32'h1234_5678, 2'b00);
    expect_lookup("R8 third victim gone", 32'h0002_0678, LD, S_WALK, 32'h0, 32'h0002_0678, 2'b00);
    expect_lookup("R8 entry 3 survives", 32'h0003_0678, LD, S_HIT, 32'h0BAD_F00D, 32'h0077_7678, 2'b01);
    expect_lookup("R8 entry 7 mapped", 32'h0004_3000, LD, S_MEM, 32'h0, 32'h0014_3000, 2'b00);
    expect_lookup("R8 wrapped fill mapped", 32'h0005_0004, ST, S_MEM, 32'h0, 32'h0025_0004, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_rights = '0;
    refill_valid = 1'b0; refill_waddr = '0; refill_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_walk();
    t_miss_then_hit();
    t_dirty();
    t_rights();
    t_conflict();
    t_back_to_back();
    t_byte_offset();
    t_round_robin();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule